// File: doc/BRIEF.md
# Three-Weight Scan Pattern Decompressor

The block takes one compressed generator word and expands it into a series of full scan patterns. The word holds N positions, and each position carries a two-bit code: fixed 0, fixed 1, don't-care, or conflict. Each expanded pattern is N bits long. The patterns are sent to a serial scan output, one bit per clock. Position 0 goes first.

Positions coded 0 or 1 come from a deterministic source and keep their value in every pattern. Don't-care positions take the current bit of a free-running 8-bit LFSR. For each conflict position, a control unit raises a per-position select line. This select steers a 2:1 multiplexer towards an enumeration source, which is driven by a pattern index counter. A generator with k conflict positions therefore yields exactly 2^k patterns, and together they cover every value combination over those positions.

A new generator is accepted over a valid/ready handshake. The block then spends one preparation cycle and shifts all patterns back to back, with no idle cycle between them. It returns to idle after the last bit and can accept the next generator.

Top module: `tw_scan_decomp`

## Requirements
- R1: After reset, gen_ready_o is 1 and scan_valid_o, pattern_done_o and all_done_o are 0.
- R2: Position i of gen_i occupies bits [2i+1:2i], with codes 00 = fixed 0, 01 = fixed 1, 10 = don't-care, 11 = conflict. In every pattern, a fixed position outputs its own value.
- R3: A generator with k conflict positions produces exactly 2^k patterns of N bits each. Bits are shifted position 0 first, one per clock, with scan_valid_o high continuously from the first bit to the last.
- R4: In pattern p, counting from 0, the conflict position of rank j outputs bit j of p. The rank j is the number of conflict positions below that position.
- R5: A don't-care position outputs bit 7 of an 8-bit LFSR. The LFSR resets to 8'h0D and steps as s <= {s[6:0], s[7]^s[5]^s[4]^s[3]} once for every bit shifted, whatever the bit's code. Its state carries on from one generator to the next.
- R6: pattern_done_o is 1 exactly during the last bit (position N-1) of each pattern.
- R7: all_done_o is 1 exactly during the last bit of the final pattern. gen_ready_o is 1 again in the next cycle.
- R8: A generator is captured when gen_valid_i and gen_ready_o are both 1. gen_ready_o drops in the next cycle, the first bit appears one cycle after that, and gen_i and gen_valid_i have no effect while the block is busy.
- R9: A generator with no conflict positions yields one pattern, and a generator made only of conflict positions yields 2^N patterns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| gen_i | input | 2*N | Generator word, two-bit code per position |
| gen_valid_i | input | 1 | Generator word is valid |
| gen_ready_o | output | 1 | Block is idle and will accept a generator |
| scan_o | output | 1 | Serial scan data bit |
| scan_valid_o | output | 1 | scan_o carries a pattern bit this cycle |
| pattern_done_o | output | 1 | Current bit is the last bit of a pattern |
| all_done_o | output | 1 | Current bit is the last bit of the final pattern |

## Verification
The bench targets these corner cases:

- **Conflict ordering.** Rank-to-index-bit mapping is checked with conflict positions interleaved among fixed and don't-care positions. A design that ranked from the wrong end, or counted all positions instead of only conflict ones, would emit the right pattern count but in the wrong order.
- **Pattern count.** Generators with zero conflicts and with all-conflict positions exercise the extremes of the count. An off-by-one in the final-pattern compare would emit one pattern too many or too few.
- **LFSR stepping.** The LFSR is modelled across generators without reset. A design that stepped only on don't-care bits, or restarted the sequence on each generator, would show mismatched fill bits.
- **Busy-time input.** gen_i is driven with garbage while the block is busy. A design that failed to latch the generator would show corrupted fixed positions.

// File: rtl/tw_scan_pkg.sv
package tw_scan_pkg;

  typedef enum logic [1:0] {
    CODE_ZERO  = 2'b00,
    CODE_ONE   = 2'b01,
    CODE_FILL  = 2'b10,
    CODE_SWEEP = 2'b11
  } pos_code_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PREP  = 2'd1,
    ST_SHIFT = 2'd2
  } seq_state_e;

endpackage

// File: rtl/tw_scan_lfsr.sv
module tw_scan_lfsr #(
  parameter int          W        = 8,
  parameter logic [W-1:0] SEED    = 8'h0D,
  parameter logic [W-1:0] TAP_MASK = 8'hB8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic step_i,
  output logic bit_o
);

  logic [W-1:0] state_q;
  logic         fb;

  assign fb    = ^(state_q & TAP_MASK);
  assign bit_o = state_q[W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     state_q <= SEED;
    else if (step_i) state_q <= {state_q[W-2:0], fb};
  end

  // R5
  lfsr_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q != '0);

  // R5
  lfsr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |=> state_q != $past(state_q));

endmodule

// File: rtl/tw_scan_ctrl.sv
module tw_scan_ctrl #(
  parameter int N = 8,
  localparam int CW = $clog2(N + 1),
  localparam int PW = N + 1
) (
  input  logic [2*N-1:0] gen_i,
  input  logic [PW-1:0]  pat_idx_i,
  output logic [N-1:0]   sel_o,
  output logic [N-1:0]   sweep_bits_o,
  output logic [CW-1:0]  ucnt_o
);
  import tw_scan_pkg::*;

  logic [N-1:0]  is_u;
  logic [CW-1:0] rank [N];

  for (genvar i = 0; i < N; i++) begin : g_pos
    assign is_u[i]         = (gen_i[2*i +: 2] == CODE_SWEEP);
    assign sweep_bits_o[i] = is_u[i] & pat_idx_i[rank[i]];
  end

  // rank = number of conflict positions below this one
  always_comb begin
    rank[0] = '0;
    for (int i = 1; i < N; i++) rank[i] = rank[i-1] + CW'(is_u[i-1]);
  end

  assign ucnt_o = rank[N-1] + CW'(is_u[N-1]);
  assign sel_o  = is_u;

endmodule

// File: rtl/tw_scan_fixed_src.sv
module tw_scan_fixed_src #(
  parameter int N = 8
) (
  input  logic [2*N-1:0] gen_i,
  input  logic           fill_bit_i,
  output logic [N-1:0]   fixed_bits_o
);

  for (genvar i = 0; i < N; i++) begin : g_pos
    logic [1:0] code;
    assign code            = gen_i[2*i +: 2];
    assign fixed_bits_o[i] = code[1] ? fill_bit_i : code[0];
  end

endmodule

// File: rtl/tw_scan_decomp.sv
module tw_scan_decomp #(
  parameter int N = 8,
  parameter int LFSR_W = 8,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 8'h0D,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 8'hB8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [2*N-1:0] gen_i,
  input  logic           gen_valid_i,
  output logic           gen_ready_o,
  output logic           scan_o,
  output logic           scan_valid_o,
  output logic           pattern_done_o,
  output logic           all_done_o
);
  import tw_scan_pkg::*;

  localparam int CW = $clog2(N + 1);
  localparam int BW = (N > 1) ? $clog2(N) : 1;
  localparam int PW = N + 1;

  seq_state_e     state_q;
  logic [2*N-1:0] gen_q;
  logic [BW-1:0]  bit_q;
  logic [PW-1:0]  pat_q;

  logic [N-1:0]  sel, sweep_bits, fixed_bits;
  logic [CW-1:0] ucnt;
  logic          fill_bit, shifting, bit_last, pat_last, accept;

  assign shifting = (state_q == ST_SHIFT);
  assign accept   = (state_q == ST_IDLE) && gen_valid_i;
  assign bit_last = (bit_q == BW'(N - 1));
  assign pat_last = (pat_q == ((PW'(1) << ucnt) - PW'(1)));

  tw_scan_lfsr #(
    .W(LFSR_W), .SEED(LFSR_SEED), .TAP_MASK(LFSR_TAPS)
  ) i_lfsr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (shifting),
    .bit_o  (fill_bit)
  );

  tw_scan_ctrl #(.N(N)) i_ctrl (
    .gen_i        (gen_q),
    .pat_idx_i    (pat_q),
    .sel_o        (sel),
    .sweep_bits_o (sweep_bits),
    .ucnt_o       (ucnt)
  );

  tw_scan_fixed_src #(.N(N)) i_fixed (
    .gen_i        (gen_q),
    .fill_bit_i   (fill_bit),
    .fixed_bits_o (fixed_bits)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      gen_q   <= '0;
      bit_q   <= '0;
      pat_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          gen_q   <= gen_i;
          state_q <= ST_PREP;
        end
        ST_PREP: begin
          bit_q   <= '0;
          pat_q   <= '0;
          state_q <= ST_SHIFT;
        end
        ST_SHIFT: begin
          if (bit_last) begin
            bit_q <= '0;
            if (pat_last) state_q <= ST_IDLE;
            else          pat_q   <= pat_q + PW'(1);
          end else begin
            bit_q <= bit_q + BW'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // 2:1 steering: select high picks the enumeration source
  assign scan_o         = shifting & (sel[bit_q] ? sweep_bits[bit_q] : fixed_bits[bit_q]);
  assign scan_valid_o   = shifting;
  assign pattern_done_o = shifting & bit_last;
  assign all_done_o     = shifting & bit_last & pat_last;
  assign gen_ready_o    = (state_q == ST_IDLE);

  // R7
  final_is_pattern_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    all_done_o |-> pattern_done_o);

  // R7
  ready_return_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    all_done_o |=> gen_ready_o);

  // R8
  busy_after_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gen_valid_i && gen_ready_o) |=> !gen_ready_o);

  // R8
  first_bit_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gen_valid_i && gen_ready_o) |=> ##1 scan_valid_o);

  // R3
  no_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scan_valid_o && !all_done_o) |=> scan_valid_o);

  // R8
  gen_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scan_valid_o && !all_done_o) |=> $stable(gen_q));

endmodule

// File: tb/test_tw_scan_decomp.sv
module test_tw_scan_decomp;
  localparam int N = 8;

  logic           clk_i = 1'b0;
  logic           rst_ni = 1'b0;
  logic [2*N-1:0] gen_i = '0;
  logic           gen_valid_i = 1'b0;
  logic           gen_ready_o, scan_o, scan_valid_o, pattern_done_o, all_done_o;

  int checks = 0;
  int fails  = 0;
  logic [7:0] model = 8'h0D;

  always #10 clk_i = ~clk_i;

  tw_scan_decomp #(.N(N)) i_tw_scan_decomp (
    .clk_i, .rst_ni, .gen_i, .gen_valid_i, .gen_ready_o,
    .scan_o, .scan_valid_o, .pattern_done_o, .all_done_o
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // caller sits just after a negedge with block idle
  task automatic run_gen(input logic [2*N-1:0] g);
    int k;
    int last_p;
    k = 0;
    for (int i = 0; i < N; i++) if (g[2*i +: 2] == 2'b11) k++;
    last_p = (1 << k) - 1;
    gen_i = g;
    gen_valid_i = 1'b1;
    @(negedge clk_i);
    chk(gen_ready_o == 1'b0, "R8 ready low after accept", gen_ready_o, 0);
    chk(scan_valid_o == 1'b0, "R8 prep cycle idle", scan_valid_o, 0);
    gen_i = ~g;  // ignored while busy
    @(negedge clk_i);
    for (int p = 0; p <= last_p; p++) begin
      int rank;
      rank = 0;
      for (int b = 0; b < N; b++) begin
        logic [1:0] c;
        logic       e;
        string      req;
        c = g[2*b +: 2];
        case (c)
          2'b00:   begin e = 1'b0;     req = "R2 fixed zero"; end
          2'b01:   begin e = 1'b1;     req = "R2 fixed one"; end
          2'b10:   begin e = model[7]; req = "R5 lfsr fill"; end
          default: begin e = p[rank];  req = "R4 conflict enum"; rank++; end
        endcase
        model = {model[6:0], model[7] ^ model[5] ^ model[4] ^ model[3]};
        chk(scan_valid_o == 1'b1, "R3 continuous valid", scan_valid_o, 1);
        chk(scan_o == e, req, scan_o, e);
        chk(pattern_done_o == (b == N-1), "R6 pattern end", pattern_done_o, b == N-1);
        chk(all_done_o == (b == N-1 && p == last_p), "R7 final end", all_done_o,
            b == N-1 && p == last_p);
        @(negedge clk_i);
      end
    end
    chk(gen_ready_o == 1'b1, "R7 ready back", gen_ready_o, 1);
    chk(scan_valid_o == 1'b0, "R3 pattern count", scan_valid_o, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1
    chk(gen_ready_o == 1'b1, "R1 ready in reset", gen_ready_o, 1);
    chk(scan_valid_o == 1'b0, "R1 valid in reset", scan_valid_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(gen_ready_o == 1'b1, "R1 ready after reset", gen_ready_o, 1);
    chk(scan_valid_o == 1'b0, "R1 valid after reset", scan_valid_o, 0);
    chk(pattern_done_o == 1'b0 && all_done_o == 1'b0, "R1 done flags", pattern_done_o, 0);

    run_gen(16'hAAAA);                 // R5 seed sequence, R9 zero conflicts
    run_gen(16'b0100_0101_0000_0100);  // R2 fixed only, R9
    run_gen(16'b0110_1100_0111_1011);  // R4 three interleaved conflicts
    run_gen(16'hFFFF);                 // R9 all conflicts
    for (int s = 1; s <= 12; s++) begin
      run_gen(16'((s * 40503) ^ (s << 7) ^ 16'h5A3C));
    end
    gen_valid_i = 1'b0;
    @(negedge clk_i);
    chk(gen_ready_o == 1'b1, "R7 stays idle", gen_ready_o, 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule